// File: doc/BRIEF.md
# Four-Rail Power Sequencer

This block brings up and tears down four supply rails that feed a group of logic devices. Software sets one enable bit through a byte-wide register port. The block then switches the rails on one after another, in a fixed ascending order. Each rail must report its power-good before the next one is started. When software clears the bit, the rails are switched off in the opposite order, and each rail waits for its power-good to drop. If a rail does not come up within its timeout, or the external alarm input fires, every rail is cut in the same cycle. The block then latches an alarm bit and records which rail failed.

After every power-down, the block waits through a fixed discharge interval before it honours an enable again. This keeps the sequencer out of a state where it waits forever for power-goods that cannot come, when software toggles the enable quickly. An enable written during a power-down or a discharge is held and acted on once the interval ends. Software reads a status byte that holds the live power-good flags together with the alarm bit. The supply counts as good only when that byte equals 0x0F.

Top module: `pwr_rail_seq`

## Requirements
- R1: Byte registers decode at fixed offsets: 0x2000 reads the VERSION parameter (default 0x03), 0x2006 is control, 0x200A is status and 0x200B is the fail register. Any other offset reads 0x00. Writes to any offset other than control change nothing.
- R2: Control bit 0 holds the requested enable. Control reads back as that bit, with bits 7:1 always zero.
- R3: Status bits 3:0 mirror the four power-good inputs live, bit 4 is the latched alarm and bits 7:5 read zero. Supply is good only when status reads exactly 0x0F.
- R4: On enable, rail k (k = 1..3) is switched on only after the power-good of rail k-1 was seen high. The order is rail 0, then 1, 2, 3, and all four end up on.
- R5: On disable, the rails are switched off from rail 3 down to rail 0. Rail k turns off only when rail k+1 is already off, and each step waits for the rail's power-good to drop or for DOWN_TIMEOUT cycles.
- R6: After a power-down completes, no rail is switched on for DRAIN_CYCLES cycles. An enable written during power-down or discharge is honoured afterwards, so rapid toggling always ends with all rails on. Exactly DRAIN_CYCLES+2 cycles pass from the fall of rail 0's power-good to the next rise of rail 0.
- R7: If the current rail's power-good does not rise within UP_TIMEOUT cycles of that rail being switched on, all rails turn off in the same cycle. The alarm bit is set and fail register bit k is set for the failing rail k. The failing rail stays on for exactly UP_TIMEOUT cycles.
- R8: The alarm input, while rails are ramping up or fully on, turns all rails off in the same cycle and sets the alarm bit. It leaves the fail register unchanged.
- R9: While the alarm is latched, the rails stay off even if enable is written to 1. Writing control with bit 0 clear clears both the alarm bit and the fail register.
- R10: After reset, all rail enables are low and the control, fail and alarm bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 14 | Byte register offset, used for both reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pgood_in | input | 4 | Power-good flag of each rail |
| alarm_in | input | 1 | External fault alarm |
| rail_en | output | 4 | Switch-on command of each rail |

## Verification
The bench builds the block with UP_TIMEOUT = 200, DOWN_TIMEOUT = 150 and DRAIN_CYCLES = 300, where the defaults are counts of 10^8 cycles. With these values the per-rail timeout, the fault latching on each of the four rails and the exact discharge gap all fall within a few hundred cycles. A behavioural rail model with randomised switch-on and switch-off delays drives the power-good inputs. A stuck flag on each rail provokes the timeout. Randomised enable toggling with short gaps then shows that the sequencer always comes back to all rails on.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // Layout of the status byte fixes the rail count.
    localparam int NUM_RAILS = 4;
    localparam int ADDR_W    = 14;
    localparam int IDX_W     = $clog2(NUM_RAILS);

    localparam logic [ADDR_W-1:0] OFS_VERSION = 14'h2000;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 14'h2006;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 14'h200A;
    localparam logic [ADDR_W-1:0] OFS_FAIL    = 14'h200B;

    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_UP,
        SQ_ON,
        SQ_DOWN,
        SQ_DRAIN,
        SQ_FAULT
    } seq_state_e;

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
    } seq_reg_t;

    typedef struct packed {
        logic                 enable;
        logic                 alarm;
        logic [NUM_RAILS-1:0] fail;
    } reg_file_t;

endpackage

// File: rtl/pseq_timer.sv
module pseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/pseq_regs.sv
module pseq_regs
    import pwr_seq_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic [7:0]           wdata,
    input  logic [NUM_RAILS-1:0] pgood,
    input  logic                 fault_set,
    input  logic [NUM_RAILS-1:0] fault_mask,
    output logic                 enable,
    output logic                 alarm,
    output logic [7:0]           rdata
);

    reg_file_t rf_d, rf_q;
    logic      unused_wbits;

    assign unused_wbits = ^wdata[7:1];

    always_comb begin
        rf_d = rf_q;
        if (wr && addr == OFS_CTRL) begin
            rf_d.enable = wdata[0];
            if (!wdata[0]) begin
                rf_d.alarm = 1'b0;
                rf_d.fail  = '0;
            end
        end
        // A fault reported in the same cycle as a clearing write wins.
        if (fault_set) begin
            rf_d.alarm = 1'b1;
            rf_d.fail  = rf_d.fail | fault_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_VERSION: rdata = VERSION;
            OFS_CTRL:    rdata = {7'b0, rf_q.enable};
            OFS_STATUS:  rdata = {3'b0, rf_q.alarm, pgood};
            OFS_FAIL:    rdata = {{(8 - NUM_RAILS){1'b0}}, rf_q.fail};
            default:     rdata = 8'h00;
        endcase
    end

    assign enable = rf_q.enable;
    assign alarm  = rf_q.alarm;

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int UP_TIMEOUT   = 125_000_000,
    parameter int DOWN_TIMEOUT = 125_000_000,
    parameter int DRAIN_CYCLES = 62_500_000,
    parameter int W            = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 alarm_latched,
    input  logic                 alarm_in,
    input  logic [NUM_RAILS-1:0] pgood,
    input  logic [W-1:0]         count,
    output logic                 tmr_clr,
    output logic                 tmr_inc,
    output logic                 fault_set,
    output logic [NUM_RAILS-1:0] fault_mask,
    output logic [NUM_RAILS-1:0] rail_en
);

    localparam logic [W-1:0]     UP_LAST    = W'(UP_TIMEOUT - 1);
    localparam logic [W-1:0]     DOWN_LAST  = W'(DOWN_TIMEOUT - 1);
    localparam logic [W-1:0]     DRAIN_LAST = W'(DRAIN_CYCLES - 1);
    localparam logic [IDX_W-1:0] TOP_IDX    = IDX_W'(NUM_RAILS - 1);

    seq_reg_t sq_d, sq_q;

    always_comb begin
        sq_d       = sq_q;
        tmr_clr    = 1'b0;
        tmr_inc    = 1'b0;
        fault_set  = 1'b0;
        fault_mask = '0;
        unique case (sq_q.st)
            SQ_OFF: begin
                if (enable && !alarm_latched) begin
                    sq_d.st  = SQ_UP;
                    sq_d.idx = '0;
                    tmr_clr  = 1'b1;
                end
            end
            SQ_UP: begin
                if (alarm_in) begin
                    sq_d.st   = SQ_FAULT;
                    fault_set = 1'b1;
                end else if (!enable) begin
                    sq_d.st = SQ_DOWN;
                    tmr_clr = 1'b1;
                end else if (pgood[sq_q.idx]) begin
                    tmr_clr = 1'b1;
                    if (sq_q.idx == TOP_IDX) begin
                        sq_d.st = SQ_ON;
                    end else begin
                        sq_d.idx = sq_q.idx + 1'b1;
                    end
                end else if (count == UP_LAST) begin
                    sq_d.st               = SQ_FAULT;
                    fault_set             = 1'b1;
                    fault_mask[sq_q.idx]  = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            SQ_ON: begin
                if (alarm_in) begin
                    sq_d.st   = SQ_FAULT;
                    fault_set = 1'b1;
                end else if (!enable) begin
                    sq_d.st  = SQ_DOWN;
                    sq_d.idx = TOP_IDX;
                    tmr_clr  = 1'b1;
                end
            end
            SQ_DOWN: begin
                if (!pgood[sq_q.idx] || count == DOWN_LAST) begin
                    tmr_clr = 1'b1;
                    if (sq_q.idx == '0) begin
                        sq_d.st = SQ_DRAIN;
                    end else begin
                        sq_d.idx = sq_q.idx - 1'b1;
                    end
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            SQ_DRAIN: begin
                if (count == DRAIN_LAST) begin
                    sq_d.st = SQ_OFF;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            SQ_FAULT: begin
                if (!enable) begin
                    sq_d.st = SQ_DRAIN;
                    tmr_clr = 1'b1;
                end
            end
            default: begin
                sq_d.st = SQ_FAULT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_OFF, idx: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    // Rails up to and including idx while ramping up; below idx while ramping down.
    always_comb begin
        for (int k = 0; k < NUM_RAILS; k++) begin
            unique case (sq_q.st)
                SQ_UP:   rail_en[k] = (k <= int'(sq_q.idx));
                SQ_DOWN: rail_en[k] = (k < int'(sq_q.idx));
                SQ_ON:   rail_en[k] = 1'b1;
                default: rail_en[k] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
    import pwr_seq_pkg::*;
#(
    parameter logic [7:0] VERSION      = 8'h03,
    parameter int         UP_TIMEOUT   = 125_000_000,
    parameter int         DOWN_TIMEOUT = 125_000_000,
    parameter int         DRAIN_CYCLES = 62_500_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [NUM_RAILS-1:0] pgood_in,
    input  logic                 alarm_in,
    output logic [NUM_RAILS-1:0] rail_en
);

    localparam int LIM_A = (UP_TIMEOUT > DOWN_TIMEOUT) ? UP_TIMEOUT : DOWN_TIMEOUT;
    localparam int LIM_M = (LIM_A > DRAIN_CYCLES) ? LIM_A : DRAIN_CYCLES;
    localparam int TW    = $clog2(LIM_M + 1);

    logic                 enable_w;
    logic                 alarm_w;
    logic                 fault_set_w;
    logic [NUM_RAILS-1:0] fault_mask_w;
    logic                 tmr_clr_w;
    logic                 tmr_inc_w;
    logic [TW-1:0]        tmr_cnt_w;

    pseq_regs #(
        .VERSION(VERSION)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .pgood      (pgood_in),
        .fault_set  (fault_set_w),
        .fault_mask (fault_mask_w),
        .enable     (enable_w),
        .alarm      (alarm_w),
        .rdata      (bus_rdata)
    );

    pseq_timer #(
        .W(TW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr_w),
        .inc   (tmr_inc_w),
        .count (tmr_cnt_w)
    );

    pseq_ctrl #(
        .UP_TIMEOUT   (UP_TIMEOUT),
        .DOWN_TIMEOUT (DOWN_TIMEOUT),
        .DRAIN_CYCLES (DRAIN_CYCLES),
        .W            (TW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable_w),
        .alarm_latched (alarm_w),
        .alarm_in      (alarm_in),
        .pgood         (pgood_in),
        .count         (tmr_cnt_w),
        .tmr_clr       (tmr_clr_w),
        .tmr_inc       (tmr_inc_w),
        .fault_set     (fault_set_w),
        .fault_mask    (fault_mask_w),
        .rail_en       (rail_en)
    );

endmodule

// File: rtl/pwr_rail_seq_chk.sv
module pwr_rail_seq_chk
    import pwr_seq_pkg::*;
#(
    parameter int DRAIN_CYCLES = 62_500_000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [7:0]           bus_wdata,
    input logic [NUM_RAILS-1:0] pgood_in,
    input logic [NUM_RAILS-1:0] rail_en,
    input logic                 enable_w,
    input logic                 alarm_w
);

    localparam int GW = $clog2(DRAIN_CYCLES + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(DRAIN_CYCLES);

    // Cycles spent with every rail off, saturating at the discharge length.
    logic [GW-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (rail_en != '0) begin
            gap_d = '0;
        end else if (gap_q < GAP_MAX) begin
            gap_d = gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_MAX;
        end else begin
            gap_q <= gap_d;
        end
    end

    for (genvar k = 1; k < NUM_RAILS; k++) begin : g_up_order
        p_rise_after_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_en[k]) |-> $past(pgood_in[k-1]));
    end

    for (genvar k = 0; k < NUM_RAILS - 1; k++) begin : g_down_order
        p_fall_after_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rail_en[k]) |-> !rail_en[k+1]);
    end

    p_drain_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en != '0 && $past(rail_en) == '0) |-> (gap_q == GAP_MAX));

    p_alarm_rails_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_w |-> (rail_en == '0));

    p_ctrl_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=> (enable_w == $past(bus_wdata[0])));

    p_other_writes_inert_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFS_CTRL) |=> $stable(enable_w));

endmodule

bind pwr_rail_seq pwr_rail_seq_chk #(
    .DRAIN_CYCLES(DRAIN_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pgood_in  (pgood_in),
    .rail_en   (rail_en),
    .enable_w  (enable_w),
    .alarm_w   (alarm_w)
);

// File: tb/pwr_rail_seq_bench.sv
`timescale 1ns/1ps
module pwr_rail_seq_bench;

    localparam int UP_TO  = 200;
    localparam int DN_TO  = 150;
    localparam int DRAIN  = 300;
    localparam logic [13:0] A_VER  = 14'h2000;
    localparam logic [13:0] A_CTL  = 14'h2006;
    localparam logic [13:0] A_STAT = 14'h200A;
    localparam logic [13:0] A_FAIL = 14'h200B;
    localparam int ON_LIMIT = 4 * UP_TO + 4 * DN_TO + DRAIN + 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  pgood = '0;
    logic        alarm_in = 1'b0;
    logic [3:0]  rail_en;

    int  n_checks = 0;
    int  n_errors = 0;
    int  ord_err = 0;
    bit  finished = 1'b0;
    int  on_dly[4], off_dly[4], on_cnt[4], off_cnt[4];
    bit  stuck[4];
    int  seed_dummy;

    always #4 clk = ~clk;

    pwr_rail_seq #(
        .VERSION      (8'h03),
        .UP_TIMEOUT   (UP_TO),
        .DOWN_TIMEOUT (DN_TO),
        .DRAIN_CYCLES (DRAIN)
    ) u_pwr_rail_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pgood_in  (pgood),
        .alarm_in  (alarm_in),
        .rail_en   (rail_en)
    );

    function automatic logic [7:0] exp_status(input logic [3:0] pg, input logic al);
        return {3'b000, al, pg};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_on(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < ON_LIMIT; i++) begin
            @(negedge clk); #1;
            if (rail_en == 4'hF && pgood == 4'hF) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_off(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < ON_LIMIT; i++) begin
            @(negedge clk); #1;
            if (rail_en == 4'h0 && pgood == 4'h0) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic settle();
        bit ok;
        wait_off(ok);
        repeat (DRAIN + 10) @(negedge clk);
    endtask

    // Behavioural rails: power-good follows the switch-on command after a delay.
    initial begin
        logic [3:0] prev_en, prev_pg;
        prev_en = '0;
        prev_pg = '0;
        forever begin
            @(negedge clk);
            for (int k = 1; k < 4; k++) begin
                if (rail_en[k] && !prev_en[k] && !prev_pg[k-1]) ord_err++;
            end
            for (int k = 0; k < 3; k++) begin
                if (!rail_en[k] && prev_en[k] && rail_en[k+1]) ord_err++;
            end
            for (int k = 0; k < 4; k++) begin
                if (rail_en[k]) begin
                    off_cnt[k] = 0;
                    if (!stuck[k]) begin
                        if (on_cnt[k] < on_dly[k]) on_cnt[k]++;
                        else pgood[k] = 1'b1;
                    end
                end else begin
                    on_cnt[k] = 0;
                    if (off_cnt[k] < off_dly[k]) off_cnt[k]++;
                    else pgood[k] = 1'b0;
                end
            end
            prev_en = rail_en;
            prev_pg = pgood;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        bit ok;
        int cnt;
        seed_dummy = $urandom(32'h5EED);
        for (int k = 0; k < 4; k++) begin
            on_dly[k]  = 2 + ($urandom % 40);
            off_dly[k] = 3 + ($urandom % 20);
            on_cnt[k]  = 0;
            off_cnt[k] = 0;
            stuck[k]   = 1'b0;
        end
        repeat (10) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        @(negedge clk); #1;
        check(rail_en == 4'h0, "R10", "rail_en after reset", rail_en, 0);
        rd(A_CTL, v);  check(v == 8'h00, "R10", "control after reset", v, 0);
        rd(A_FAIL, v); check(v == 8'h00, "R10", "fail after reset", v, 0);
        rd(A_STAT, v); check(v == exp_status(4'h0, 1'b0), "R10", "status after reset", v, 0);

        // R1 register map and inert writes
        rd(A_VER, v);  check(v == 8'h03, "R1", "version", v, 3);
        rd(14'h2001, v); check(v == 8'h00, "R1", "unmapped offset", v, 0);
        wr(A_STAT, 8'hFF);
        wr(A_FAIL, 8'hFF);
        rd(A_CTL, v);  check(v == 8'h00, "R1", "control after foreign writes", v, 0);
        rd(A_FAIL, v); check(v == 8'h00, "R1", "fail after write to it", v, 0);
        check(rail_en == 4'h0, "R1", "rails after foreign writes", rail_en, 0);

        // R2 / R3 / R4 power-up
        wr(A_CTL, 8'h81);
        rd(A_CTL, v);  check(v == 8'h01, "R2", "control readback", v, 1);
        wait_on(ok);   check(ok, "R4", "all rails on", rail_en, 15);
        rd(A_STAT, v); check(v == exp_status(4'hF, 1'b0), "R3", "status when good", v, 8'h0F);

        // R5 power-down
        wr(A_CTL, 8'h00);
        rd(A_CTL, v);  check(v == 8'h00, "R2", "control readback after clear", v, 0);
        wait_off(ok);  check(ok, "R5", "all rails off", rail_en, 0);
        rd(A_STAT, v); check(v == exp_status(4'h0, 1'b0), "R3", "status when off", v, 0);
        repeat (DRAIN + 10) @(negedge clk);

        // R6 exact discharge gap with a fast re-enable
        wr(A_CTL, 8'h01);
        wait_on(ok);   check(ok, "R6", "rails on before toggle", rail_en, 15);
        wr(A_CTL, 8'h00);
        wr(A_CTL, 8'h01);
        do begin @(negedge clk); #1; end while (!(rail_en == 4'h0 && pgood == 4'h0));
        cnt = 0;
        while (rail_en == 4'h0 && pgood == 4'h0 && cnt < ON_LIMIT) begin
            cnt++;
            @(negedge clk); #1;
        end
        check(cnt == DRAIN + 2, "R6", "discharge gap cycles", cnt, DRAIN + 2);
        wait_on(ok);   check(ok, "R6", "on after fast re-enable", rail_en, 15);

        // R6 rapid random toggling never wedges
        for (int t = 0; t < 20; t++) begin
            wr(A_CTL, 8'h00);
            repeat ($urandom % 30) @(negedge clk);
            wr(A_CTL, 8'h01);
            repeat ($urandom % 30) @(negedge clk);
        end
        wait_on(ok);   check(ok, "R6", "on after random toggling", rail_en, 15);
        wr(A_CTL, 8'h00);
        settle();

        // R7 / R9 timeout fault on each rail
        for (int k = 0; k < 4; k++) begin
            stuck[k] = 1'b1;
            wr(A_CTL, 8'h01);
            cnt = 0;
            do begin @(negedge clk); #1; cnt++; end while (!rail_en[k] && cnt < ON_LIMIT);
            cnt = 0;
            while (rail_en[k] && cnt < ON_LIMIT) begin
                cnt++;
                @(negedge clk); #1;
            end
            check(cnt == UP_TO, "R7", $sformatf("rail %0d on-time before fault", k), cnt, UP_TO);
            check(rail_en == 4'h0, "R7", "all rails cut", rail_en, 0);
            rd(A_STAT, v); check(v[4] == 1'b1, "R7", "alarm bit", v, 8'h10);
            rd(A_FAIL, v); check(v == (8'h01 << k), "R7", "fail bit", v, 1 << k);
            wr(A_CTL, 8'h01);
            repeat (40) @(negedge clk);
            #1;
            check(rail_en == 4'h0, "R9", "rails stay off while faulted", rail_en, 0);
            rd(A_FAIL, v); check(v == (8'h01 << k), "R9", "fail held", v, 1 << k);
            wr(A_CTL, 8'h00);
            rd(A_FAIL, v); check(v == 8'h00, "R9", "fail cleared", v, 0);
            rd(A_STAT, v); check(v[4] == 1'b0, "R9", "alarm cleared", v, 0);
            stuck[k] = 1'b0;
            settle();
        end

        // R8 external alarm while on
        wr(A_CTL, 8'h01);
        wait_on(ok);   check(ok, "R8", "rails on before alarm", rail_en, 15);
        @(negedge clk);
        alarm_in = 1'b1;
        @(negedge clk);
        alarm_in = 1'b0;
        #1;
        check(rail_en == 4'h0, "R8", "rails cut by alarm", rail_en, 0);
        rd(A_STAT, v); check(v[4] == 1'b1, "R8", "alarm bit set", v, 8'h10);
        rd(A_FAIL, v); check(v == 8'h00, "R8", "fail untouched", v, 0);
        wr(A_CTL, 8'h00);
        rd(A_STAT, v); check(v[4] == 1'b0, "R9", "alarm cleared after input alarm", v, 0);
        settle();

        check(ord_err == 0, "R4", "rail order violations", ord_err, 0);
        finish_run();
    end

endmodule